// File: doc/BRIEF.md
# Snapshot Clock Register Window

This block places eight clock and control registers at the top eight byte addresses of a byte-wide memory space and sends every lower address to an ordinary RAM array that sits outside it. The host reaches both through one set of level strobes: active-low chip select, output enable and write enable, plus address and data. The block samples these strobes on its own clock. The bus is not a stream, so it has no handshake. The read path is combinational and the write path commits on the clock edge.

The registers the host sees are a holding copy of a live calendar counter that runs outside the block. The counter gives a one-cycle `tick` each second. On that tick the block refreshes the time fields of the holding copy, unless the host has frozen it. A READ control bit freezes the copy so that the host can read a coherent time while the counter keeps running. A WRITE control bit also freezes the copy, so that the host can compose a new time. When WRITE is cleared, the block hands the composed time to the counter as a one-cycle load.

The control bits, the oscillator-stop and frequency-test controls, and any bits with no assigned function are held only in the copy. Counter refreshes never touch them. A battery-good flag is read-only and comes straight from an input. An access-inhibit input from power-fail sensing blocks every read and every write.

Top module: `rtc_bus_regs`

## Requirements
- R1: Byte addresses whose upper bits are all ones (the top eight) select the registers. Each register is chosen by the low three address bits: 0 control/century, 1 seconds, 2 minutes, 3 hours, 4 day, 5 date, 6 month, 7 year. Every lower address asserts `ram_rd` or `ram_wr`, and a read of it returns `ram_rdata` on `rdata`.
- R2: A read is active when `ce_n`=0, `oe_n`=0 and `we_n`=1. It sets `rd_en`=1 and drives `rdata` in the same cycle. A write is active when `ce_n`=0 and `we_n`=0, whatever `oe_n` is. A write commits on the next rising clock edge. When no read is active, `rdata` is 0.
- R3: While `inhibit`=1, `rd_en`, `ram_rd` and `ram_wr` stay 0, `rdata` is 0, and no register changes.
- R4: While READ and WRITE are both 0, a `tick` copies the counter's time fields into the copy at that clock edge. Byte i of `cnt_time` (bits 8i+7..8i) feeds register i. The time-field masks are: control 0x3F, seconds 0x7F, minutes 0x7F, hours 0x3F, day 0x07, date 0x3F, month 0x1F, year 0xFF.
- R5: Bit 6 of the control register is READ. While it is 1, ticks leave the copy unchanged and `cnt_load` stays 0.
- R6: Once READ is 0 again, the copy does not change until the next `tick`. That tick refreshes every time field together.
- R7: Bit 7 of the control register is WRITE. While it is 1, ticks are ignored and host writes land in the copy. A write that turns WRITE from 1 to 0 makes `cnt_load` high for exactly the following cycle. During that cycle `cnt_wdata` carries the time fields of the copy, masked, in the `cnt_time` byte layout. A write that sets WRITE produces no load.
- R8: `osc_stop` is bit 7 of the seconds register and `freq_test` is bit 6 of the day register. Both are read/write and survive ticks.
- R9: Bit 7 of the day register always reads as `battery_ok`. Host writes to that bit have no effect.
- R10: Bits outside the time masks that have no assigned function keep whatever the host last wrote, across ticks. These are minutes bit 7, hours bits 7..6, day bits 5..3, date bits 7..6 and month bits 7..5.
- R11: After reset, every register bit is 0 (the day register reads `battery_ok` in bit 7), and `cnt_load`, `osc_stop` and `freq_test` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (0 when no read is active) |
| rd_en | output | 1 | Read is active; `rdata` is driven |
| ram_rd | output | 1 | Read strobe to the external RAM |
| ram_wr | output | 1 | Write strobe to the external RAM |
| ram_rdata | input | 8 | Data returned by the external RAM |
| inhibit | input | 1 | Power-fail access block |
| battery_ok | input | 1 | Battery-good status |
| tick | input | 1 | One-second pulse from the live counter |
| cnt_time | input | 64 | Live counter time, one byte per register |
| cnt_load | output | 1 | One-cycle load strobe to the counter |
| cnt_wdata | output | 64 | Time to load into the counter |
| osc_stop | output | 1 | Oscillator-stop control |
| freq_test | output | 1 | Frequency-test control |

## Verification
A wrong copy-enable decision shows at the ports on the first register read after the next `tick`. Either a frozen field has moved or a tracking field is stale, so the fault appears within one tick period. A lost or doubled transfer shows in the cycle right after the write that clears WRITE, as a missing or stretched `cnt_load` or a wrong `cnt_wdata` byte. A corrupted control or storage bit shows immediately on `osc_stop` or `freq_test`, or on the next read of its register after a tick.

// File: rtl/rtcb_pkg.sv
package rtcb_pkg;
  localparam int NREG   = 8;
  localparam int IDX_W  = $clog2(NREG);
  localparam int TIME_W = NREG * 8;

  typedef enum logic [IDX_W-1:0] {
    RG_CTRL = 3'd0, RG_SEC = 3'd1, RG_MIN = 3'd2, RG_HOUR = 3'd3,
    RG_DAY  = 3'd4, RG_DATE = 3'd5, RG_MONTH = 3'd6, RG_YEAR = 3'd7
  } reg_idx_e;

  localparam int BIT_WRITE = 7;  // control register
  localparam int BIT_READ  = 6;  // control register
  localparam int BIT_OSC   = 7;  // seconds register
  localparam int BIT_FTEST = 6;  // day register
  localparam int BIT_BATT  = 7;  // day register

  // bits refreshed from the live counter
  function automatic logic [7:0] time_mask(input int idx);
    case (idx)
      0:       return 8'h3F;
      1, 2:    return 8'h7F;
      3, 5:    return 8'h3F;
      4:       return 8'h07;
      6:       return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction

  // bits the host may write
  function automatic logic [7:0] host_mask(input int idx);
    return (idx == int'(RG_DAY)) ? ~(8'h1 << BIT_BATT) : 8'hFF;
  endfunction
endpackage

// File: rtl/rtcb_bus_dec.sv
module rtcb_bus_dec
  import rtcb_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              inhibit,
  input  logic [ADDR_W-1:0] addr,
  output logic              rd_act,
  output logic              wr_act,
  output logic              top_sel,
  output logic [IDX_W-1:0]  idx,
  output logic              ram_rd,
  output logic              ram_wr
);
  logic sel;

  assign sel     = !ce_n && !inhibit;
  assign wr_act  = sel && !we_n;
  assign rd_act  = sel && we_n && !oe_n;
  assign top_sel = &addr[ADDR_W-1:IDX_W];
  assign idx     = addr[IDX_W-1:0];
  assign ram_rd  = rd_act && !top_sel;
  assign ram_wr  = wr_act && !top_sel;
endmodule

// File: rtl/rtcb_hold_bank.sv
module rtcb_hold_bank
  import rtcb_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [7:0]                 wr_data,
  input  logic                       copy_en,
  input  logic [TIME_W-1:0]          cnt_time,
  output logic [NREG-1:0][7:0]       hold_q
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [7:0] TM = time_mask(g);
    localparam logic [7:0] HM = host_mask(g);
    logic [7:0] nxt;

    always_comb begin
      nxt = hold_q[g];
      if (copy_en)
        nxt = (nxt & ~TM) | (cnt_time[g*8 +: 8] & TM);
      if (wr_en && (wr_idx == IDX_W'(g)))
        nxt = (nxt & ~HM) | (wr_data & HM);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hold_q[g] <= '0;
      else        hold_q[g] <= nxt;
    end
  end
endmodule

// File: rtl/rtcb_xfer.sv
module rtcb_xfer
  import rtcb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic [7:0]           ctrl_q,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [7:0]           wr_data,
  input  logic [NREG-1:0][7:0] hold_q,
  output logic                 copy_en,
  output logic                 cnt_load,
  output logic [TIME_W-1:0]    cnt_wdata
);
  logic halted, release_wr, load_q;

  assign halted     = ctrl_q[BIT_READ] || ctrl_q[BIT_WRITE];
  assign release_wr = wr_en && (wr_idx == IDX_W'(RG_CTRL)) &&
                      ctrl_q[BIT_WRITE] && !wr_data[BIT_WRITE];
  // a tick during the load cycle would copy a stale count back
  assign copy_en    = tick && !halted && !load_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) load_q <= 1'b0;
    else        load_q <= release_wr;
  end

  assign cnt_load = load_q;

  for (genvar g = 0; g < NREG; g++) begin : g_out
    localparam logic [7:0] TM = time_mask(g);
    assign cnt_wdata[g*8 +: 8] = hold_q[g] & TM;
  end
endmodule

// File: rtl/rtc_bus_regs.sv
module rtc_bus_regs
  import rtcb_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              rd_en,
  output logic              ram_rd,
  output logic              ram_wr,
  input  logic [7:0]        ram_rdata,
  input  logic              inhibit,
  input  logic              battery_ok,
  input  logic              tick,
  input  logic [TIME_W-1:0] cnt_time,
  output logic              cnt_load,
  output logic [TIME_W-1:0] cnt_wdata,
  output logic              osc_stop,
  output logic              freq_test
);
  logic                 rd_act, wr_act, top_sel, reg_wr, copy_en;
  logic [IDX_W-1:0]     idx;
  logic [NREG-1:0][7:0] hold_q;
  logic [7:0]           view;

  rtcb_bus_dec #(.ADDR_W(ADDR_W)) u_dec (
    .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .inhibit(inhibit), .addr(addr),
    .rd_act(rd_act), .wr_act(wr_act), .top_sel(top_sel), .idx(idx),
    .ram_rd(ram_rd), .ram_wr(ram_wr)
  );

  assign reg_wr = wr_act && top_sel;

  rtcb_hold_bank u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_idx(idx), .wr_data(wdata),
    .copy_en(copy_en), .cnt_time(cnt_time), .hold_q(hold_q)
  );

  rtcb_xfer u_xfer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ctrl_q(hold_q[RG_CTRL]),
    .wr_en(reg_wr), .wr_idx(idx), .wr_data(wdata), .hold_q(hold_q),
    .copy_en(copy_en), .cnt_load(cnt_load), .cnt_wdata(cnt_wdata)
  );

  always_comb begin
    view = hold_q[idx];
    if (idx == IDX_W'(RG_DAY)) view[BIT_BATT] = battery_ok;
  end

  assign rd_en     = rd_act;
  assign rdata     = !rd_act ? 8'h00 : (top_sel ? view : ram_rdata);
  assign osc_stop  = hold_q[RG_SEC][BIT_OSC];
  assign freq_test = hold_q[RG_DAY][BIT_FTEST];
endmodule

// File: rtl/rtcb_chk.sv
module rtcb_chk
  import rtcb_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ce_n,
  input logic                 oe_n,
  input logic                 we_n,
  input logic                 inhibit,
  input logic [ADDR_W-1:0]    addr,
  input logic [7:0]           wdata,
  input logic [7:0]           rdata,
  input logic                 rd_en,
  input logic                 ram_rd,
  input logic                 ram_wr,
  input logic [7:0]           ram_rdata,
  input logic                 battery_ok,
  input logic                 cnt_load,
  input logic [NREG-1:0][7:0] hold_q
);
  logic hi, any_wr, top_wr, ctrl_clear;

  assign hi         = &addr[ADDR_W-1:IDX_W];
  assign any_wr     = !ce_n && !we_n && !inhibit;
  assign top_wr     = any_wr && hi;
  assign ctrl_clear = top_wr && (addr[IDX_W-1:0] == IDX_W'(RG_CTRL)) &&
                      !wdata[BIT_WRITE] && hold_q[RG_CTRL][BIT_WRITE];

  // R3
  inhibit_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |-> (!rd_en && !ram_rd && !ram_wr && rdata == 8'h00));

  // R2
  write_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_wr && !hi) |-> (ram_wr && !ram_rd && !rd_en));

  // R1
  ram_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && we_n && !inhibit && !hi) |-> (rd_en && rdata == ram_rdata));

  // R5
  read_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q[RG_CTRL][BIT_READ] && !top_wr) |=> $stable(hold_q));

  // R7
  load_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_load |=> !cnt_load);

  // R7
  load_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_clear |=> cnt_load));

  // R9
  battery_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && hi && addr[IDX_W-1:0] == IDX_W'(RG_DAY)) |-> (rdata[BIT_BATT] == battery_ok));
endmodule

bind rtc_bus_regs rtcb_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .inhibit(inhibit), .addr(addr), .wdata(wdata), .rdata(rdata),
  .rd_en(rd_en), .ram_rd(ram_rd), .ram_wr(ram_wr), .ram_rdata(ram_rdata),
  .battery_ok(battery_ok), .cnt_load(cnt_load), .hold_q(hold_q)
);

// File: tb/sim_rtc_bus_regs.sv
`timescale 1ns/1ps
module sim_rtc_bus_regs;
  localparam int AW = 11;
  localparam logic [AW-1:0] BASE = 11'h7F8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0, ram_rdata = 8'h00;
  logic inhibit = 1'b0, battery_ok = 1'b1, tick = 1'b0;
  logic [63:0] cnt_time = '0;
  logic [7:0] rdata;
  logic rd_en, ram_rd, ram_wr, cnt_load, osc_stop, freq_test;
  logic [63:0] cnt_wdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rtc_bus_regs #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rd_en(rd_en),
    .ram_rd(ram_rd), .ram_wr(ram_wr), .ram_rdata(ram_rdata),
    .inhibit(inhibit), .battery_ok(battery_ok), .tick(tick),
    .cnt_time(cnt_time), .cnt_load(cnt_load), .cnt_wdata(cnt_wdata),
    .osc_stop(osc_stop), .freq_test(freq_test)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; tick = 1'b0;
    inhibit = 1'b0; battery_ok = 1'b1; cnt_time = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
    #2 d = rdata;
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  // byte layout: byte i feeds register i
  function automatic logic [63:0] pack(input logic [7:0] c, s, mi, h, dy, dt, mo, y);
    return {y, mo, dt, dy, h, mi, s, c};
  endfunction

  task automatic t_reset();
    logic [7:0] d;
    do_reset();
    #2;
    check("R11 cnt_load after reset", cnt_load, 1'b0);
    check("R11 osc_stop after reset", osc_stop, 1'b0);
    check("R11 freq_test after reset", freq_test, 1'b0);
    for (int i = 0; i < 8; i++) begin
      bus_read(BASE + AW'(i), d);
      check($sformatf("R11 register %0d after reset", i), d, (i == 4) ? 8'h80 : 8'h00);
    end
  endtask

  task automatic t_ram_path();
    do_reset();
    ram_rdata = 8'hA5;
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = 11'h100;
    #2;
    check("R1 ram read rdata", rdata, 8'hA5);
    check("R2 ram read strobes", {rd_en, ram_rd, ram_wr}, 3'b110);
    we_n = 1'b0; addr = BASE - 11'd1;
    #2;
    check("R2 write wins over output enable", {rd_en, ram_rd, ram_wr}, 3'b001);
    check("R2 rdata idle during write", rdata, 8'h00);
    ce_n = 1'b1;
    #2;
    check("R2 deselected strobes", {rd_en, ram_rd, ram_wr}, 3'b000);
    oe_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic t_tracking();
    logic [7:0] d;
    do_reset();
    cnt_time = pack(8'h20, 8'h45, 8'h30, 8'h14, 8'h03, 8'h28, 8'h02, 8'h24);
    bus_write(BASE + 11'd2, 8'h80);
    pulse_tick();
    bus_read(BASE + 11'd0, d); check("R4 century tracked", d, 8'h20);
    bus_read(BASE + 11'd1, d); check("R4 seconds tracked", d, 8'h45);
    bus_read(BASE + 11'd2, d); check("R10 minutes storage bit kept", d, 8'hB0);
    bus_read(BASE + 11'd4, d); check("R4 day tracked with battery", d, 8'h83);
    bus_read(BASE + 11'd7, d); check("R4 year tracked", d, 8'h24);
    check("R4 no load while tracking", cnt_load, 1'b0);
  endtask

  task automatic t_read_freeze();
    logic [7:0] d;
    do_reset();
    cnt_time = pack(8'h20, 8'h10, 8'h01, 8'h02, 8'h01, 8'h01, 8'h01, 8'h01);
    pulse_tick();
    bus_write(BASE, 8'h40);
    cnt_time = pack(8'h21, 8'h20, 8'h05, 8'h06, 8'h02, 8'h02, 8'h03, 8'h50);
    pulse_tick();
    check("R5 no load while frozen", cnt_load, 1'b0);
    bus_read(BASE + 11'd1, d); check("R5 seconds frozen", d, 8'h10);
    bus_read(BASE + 11'd7, d); check("R5 year frozen", d, 8'h01);
    bus_read(BASE, d);         check("R5 control reads back", d, 8'h40);
    bus_write(BASE, 8'h00);
    bus_read(BASE + 11'd1, d); check("R6 no refresh before tick", d, 8'h10);
    pulse_tick();
    bus_read(BASE + 11'd1, d); check("R6 seconds refreshed", d, 8'h20);
    bus_read(BASE + 11'd7, d); check("R6 year refreshed", d, 8'h50);
    bus_read(BASE, d);         check("R6 century refreshed", d, 8'h21);
  endtask

  task automatic t_write_load();
    logic [7:0] d;
    do_reset();
    cnt_time = pack(8'h19, 8'h01, 8'h01, 8'h01, 8'h01, 8'h01, 8'h01, 8'h01);
    bus_write(BASE, 8'h80);
    check("R7 setting WRITE gives no load", cnt_load, 1'b0);
    bus_write(BASE + 11'd1, 8'h33);
    bus_write(BASE + 11'd2, 8'h22);
    bus_write(BASE + 11'd3, 8'h11);
    bus_write(BASE + 11'd4, 8'h05);
    bus_write(BASE + 11'd5, 8'h15);
    bus_write(BASE + 11'd6, 8'h07);
    bus_write(BASE + 11'd7, 8'h99);
    pulse_tick();
    bus_read(BASE + 11'd1, d); check("R7 tick ignored while WRITE set", d, 8'h33);
    check("R7 no load before release", cnt_load, 1'b0);
    bus_write(BASE, 8'h21);
    check("R7 load pulse after release", cnt_load, 1'b1);
    check("R7 load data", cnt_wdata, pack(8'h21, 8'h33, 8'h22, 8'h11, 8'h05, 8'h15, 8'h07, 8'h99));
    @(negedge clk);
    check("R7 load lasts one cycle", cnt_load, 1'b0);
  endtask

  task automatic t_ctrl_bits();
    logic [7:0] d;
    do_reset();
    bus_write(BASE + 11'd1, 8'h80);
    bus_write(BASE + 11'd4, 8'h40);
    cnt_time = pack(8'h00, 8'h11, 8'h00, 8'h00, 8'h06, 8'h00, 8'h00, 8'h00);
    pulse_tick();
    check("R8 osc_stop held across tick", osc_stop, 1'b1);
    check("R8 freq_test held across tick", freq_test, 1'b1);
    bus_read(BASE + 11'd1, d); check("R8 seconds with stop bit", d, 8'h91);
    bus_write(BASE + 11'd1, 8'h11);
    check("R8 osc_stop cleared", osc_stop, 1'b0);
  endtask

  task automatic t_battery();
    logic [7:0] d;
    do_reset();
    bus_write(BASE + 11'd4, 8'h80);
    battery_ok = 1'b0;
    bus_read(BASE + 11'd4, d); check("R9 write to battery bit ignored", d, 8'h00);
    battery_ok = 1'b1;
    bus_read(BASE + 11'd4, d); check("R9 battery bit follows input", d, 8'h80);
  endtask

  task automatic t_storage();
    logic [7:0] d;
    do_reset();
    bus_write(BASE + 11'd6, 8'hE0);
    bus_write(BASE + 11'd3, 8'hC0);
    bus_write(BASE + 11'd5, 8'hC0);
    cnt_time = pack(8'h00, 8'h00, 8'h00, 8'h14, 8'h00, 8'h31, 8'h12, 8'h00);
    pulse_tick();
    bus_read(BASE + 11'd6, d); check("R10 month storage bits", d, 8'hF2);
    bus_read(BASE + 11'd3, d); check("R10 hours storage bits", d, 8'hD4);
    bus_read(BASE + 11'd5, d); check("R10 date storage bits", d, 8'hF1);
  endtask

  task automatic t_inhibit();
    logic [7:0] d;
    do_reset();
    bus_write(BASE + 11'd2, 8'h12);
    inhibit = 1'b1;
    bus_write(BASE + 11'd2, 8'h55);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = BASE + 11'd2;
    #2;
    check("R3 read blocked", {rd_en, rdata}, 9'h000);
    addr = 11'h040; we_n = 1'b0;
    #2;
    check("R3 ram write blocked", {ram_rd, ram_wr}, 2'b00);
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
    inhibit = 1'b0;
    bus_read(BASE + 11'd2, d); check("R3 register unchanged", d, 8'h12);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    t_reset();
    t_ram_path();
    t_tracking();
    t_read_freeze();
    t_write_load();
    t_ctrl_bits();
    t_battery();
    t_storage();
    t_inhibit();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule